// File: doc/BRIEF.md
# Line-Synchronized Phase-Angle Trigger Generator

This block drives the gate of a triac in series with a lamp. It places one short, active-low firing pulse in every half-cycle of the AC line. The pulse position comes from a conduction-angle code given in degrees. A squared-up copy of the line is brought into the system clock domain. The block measures the time between successive sync transitions, where each transition marks the start of a half-cycle. A fine phase pointer then sweeps 0 to 180 degree ticks across the next half-cycle, scaled to the measured length.

A conduction angle of φ degrees fires the pulse (180 − φ) ticks after the half-cycle starts, so a larger angle gives an earlier pulse and a brighter lamp. Angle code 0 means the lamp is off. Any other code is held to the usable window of 41° to 159°. Because the timing is measured again every half-cycle, the firing point follows any line frequency from 40 Hz to 70 Hz and any drift within that range. The block stays silent until it has a trustworthy measurement. It goes silent again when the sync input stops or shows an interval too short to be a half-cycle.

Top module: `phase_trigger_gen`

## Requirements
- R1: While locked and with a nonzero angle code, exactly one falling edge of `trig_n` occurs in each half-cycle, where a half-cycle is the interval between successive transitions of `line_sync`, either rising or falling.
- R2: Each firing pulse holds `trig_n` low for exactly PULSE_CYC = CLK_HZ/1000 × PULSE_NS / 1,000,000 clock cycles (33 µs by default), and never longer.
- R3: The pulse falls (180 − φ) / 180 of the measured half-period after the synchronized sync transition, within a few cycles. The half-period in use is the previous one. This holds for line frequencies from 40 to 70 Hz.
- R4: Angle codes 1 to 40 behave as 41, and codes 160 to 255 behave as 159.
- R5: Angle code 0 means off: `trig_n` stays high for as long as that code is the one in effect.
- R6: The angle code is sampled only at the start of a half-cycle. A change during a half-cycle moves neither the pulse of that half-cycle nor its count, and it takes effect in the next half-cycle.
- R7: If no sync transition arrives for CLK_HZ/35 cycles, the block unlocks and `trig_n` stays high. The first half-cycle after sync resumes produces no pulse, and the second one does.
- R8: After reset, `trig_n` is high. The half-cycle that begins at the first sync transition produces no pulse, and the half-cycle that begins at the second transition does.
- R9: An interval between sync transitions shorter than CLK_HZ/(2 × MAX_LINE_HZ) cycles unlocks the block, so no pulse occurs in the half-cycle that follows. The next interval of normal length locks the block again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, frequency CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_sync | input | 1 | Squared-up line signal, asynchronous to clk |
| cond_deg | input | 8 | Conduction angle in degrees; 0 = off |
| trig_n | output | 1 | Active-low triac firing pulse |

## Verification
The properties assume that `line_sync` is a clean square wave. They also assume that a normal half-period is well over 180 clock cycles, so the phase pointer steps at most once per clock and never passes the firing point inside a pulse. The bench drives the sync input only at falling clock edges. It keeps normal half-periods between the 70 Hz and 40 Hz lengths. It produces short intervals and long outages only on purpose, to exercise the unlock paths. It changes the angle code only from the bench side, well inside a half-cycle.

// File: rtl/phtrig_pkg.sv
package phtrig_pkg;
    localparam int DEG_HALF = 180;
    localparam int ANG_LO   = 41;
    localparam int ANG_HI   = 159;
    localparam int ANG_W    = 8;

    typedef logic [ANG_W-1:0] ang_t;

    // 0 keeps meaning "off"; anything else is held to the usable window
    function automatic ang_t limit_angle(input ang_t code);
        ang_t r;
        if (code == '0)
            r = '0;
        else if (code < ANG_W'(ANG_LO))
            r = ANG_W'(ANG_LO);
        else if (code > ANG_W'(ANG_HI))
            r = ANG_W'(ANG_HI);
        else
            r = code;
        return r;
    endfunction
endpackage

// File: rtl/sync_edge_detect.sv
module sync_edge_detect #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic edge_o
);
    localparam int SH_W = STAGES + 1;

    logic [SH_W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[SH_W-2:0], raw_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    // either polarity of transition starts a half-cycle
    assign edge_o = sh_q[SH_W-1] ^ sh_q[SH_W-2];
endmodule

// File: rtl/period_meter.sv
module period_meter #(
    parameter int CNT_W       = 15,
    parameter int TIMEOUT_CYC = 28571,
    parameter int HALF_MIN    = 6250
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             edge_i,
    output logic [CNT_W-1:0] half_o,
    output logic             lock_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] half;
        logic             seen;
        logic             locked;
    } pm_t;

    pm_t st_d, st_q;
    logic [CNT_W:0] interval;

    always_comb begin
        st_d     = st_q;
        interval = {1'b0, st_q.cnt} + (CNT_W+1)'(1);
        if (st_q.cnt != CNT_W'(TIMEOUT_CYC))
            st_d.cnt = st_q.cnt + CNT_W'(1);
        if (edge_i) begin
            st_d.cnt  = '0;
            st_d.seen = 1'b1;
            if (st_q.seen && interval >= (CNT_W+1)'(HALF_MIN)) begin
                st_d.half   = interval[CNT_W-1:0];
                st_d.locked = 1'b1;
            end else begin
                st_d.locked = 1'b0;
            end
        end else if (st_q.cnt == CNT_W'(TIMEOUT_CYC - 1)) begin
            st_d.locked = 1'b0;
            st_d.seen   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign half_o = st_q.half;
    assign lock_o = st_q.locked;
endmodule

// File: rtl/phase_pointer.sv
module phase_pointer
    import phtrig_pkg::*;
#(
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_i,
    input  logic [CNT_W-1:0] half_i,
    output logic [7:0]       deg_o
);
    typedef struct packed {
        logic [CNT_W:0] acc;
        logic [7:0]     deg;
    } pp_t;

    pp_t st_d, st_q;
    logic [CNT_W:0] acc_sum;

    // fractional stepping: add 180 per clock, step a degree per half-period
    always_comb begin
        st_d    = st_q;
        acc_sum = st_q.acc + (CNT_W+1)'(DEG_HALF);
        if (restart_i) begin
            st_d.acc = '0;
            st_d.deg = '0;
        end else if (st_q.deg < 8'(DEG_HALF)) begin
            if (acc_sum >= {1'b0, half_i}) begin
                st_d.acc = acc_sum - {1'b0, half_i};
                st_d.deg = st_q.deg + 8'd1;
            end else begin
                st_d.acc = acc_sum;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign deg_o = st_q.deg;
endmodule

// File: rtl/fire_stage.sv
module fire_stage
    import phtrig_pkg::*;
#(
    parameter int PULSE_CYC = 33,
    parameter int PW_W      = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart_i,
    input  logic       lock_i,
    input  logic [7:0] deg_i,
    input  ang_t       code_i,
    output ang_t       ang_o,
    output logic       trig_n_o
);
    typedef struct packed {
        ang_t            ang;
        logic            fired;
        logic [PW_W-1:0] pcnt;
    } fs_t;

    fs_t  st_d, st_q;
    logic [7:0] target;

    always_comb begin
        st_d   = st_q;
        target = 8'(DEG_HALF) - st_q.ang;
        if (restart_i) begin
            st_d.ang   = limit_angle(code_i);
            st_d.fired = 1'b0;
        end
        if (!lock_i) begin
            st_d.pcnt = '0;
        end else if (st_q.pcnt != '0) begin
            st_d.pcnt = st_q.pcnt - PW_W'(1);
        end else if (!restart_i && st_q.ang != '0 && !st_q.fired
                     && deg_i == target) begin
            st_d.pcnt  = PW_W'(PULSE_CYC);
            st_d.fired = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ang_o    = st_q.ang;
    assign trig_n_o = (st_q.pcnt == '0);
endmodule

// File: rtl/phase_trigger_gen.sv
module phase_trigger_gen
    import phtrig_pkg::*;
#(
    parameter int CLK_HZ      = 1_000_000,
    parameter int PULSE_NS    = 33_000,
    parameter int TIMEOUT_HZ  = 35,
    parameter int MAX_LINE_HZ = 80,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_sync,
    input  logic [7:0] cond_deg,
    output logic       trig_n
);
    localparam int PULSE_RAW   = (CLK_HZ / 1000) * PULSE_NS / 1_000_000;
    localparam int PULSE_CYC   = (PULSE_RAW < 1) ? 1 : PULSE_RAW;
    localparam int PW_W        = $clog2(PULSE_CYC + 1);
    localparam int TIMEOUT_CYC = CLK_HZ / TIMEOUT_HZ;
    localparam int HALF_MIN    = CLK_HZ / (2 * MAX_LINE_HZ);
    localparam int CNT_W       = $clog2(TIMEOUT_CYC + 1);

    logic             edge_w;
    logic [CNT_W-1:0] half_w;
    logic             lock_w;
    logic [7:0]       deg_w;
    ang_t             ang_w;

    sync_edge_detect #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (line_sync),
        .edge_o (edge_w)
    );

    period_meter #(
        .CNT_W       (CNT_W),
        .TIMEOUT_CYC (TIMEOUT_CYC),
        .HALF_MIN    (HALF_MIN)
    ) u_meter (
        .clk    (clk),
        .rst_n  (rst_n),
        .edge_i (edge_w),
        .half_o (half_w),
        .lock_o (lock_w)
    );

    phase_pointer #(.CNT_W(CNT_W)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (edge_w),
        .half_i    (half_w),
        .deg_o     (deg_w)
    );

    fire_stage #(.PULSE_CYC(PULSE_CYC), .PW_W(PW_W)) u_fire (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (edge_w),
        .lock_i    (lock_w),
        .deg_i     (deg_w),
        .code_i    (cond_deg),
        .ang_o     (ang_w),
        .trig_n_o  (trig_n)
    );
endmodule

// File: rtl/phtrig_checker.sv
module phtrig_checker #(
    parameter int PULSE_CYC = 33
) (
    input logic       clk,
    input logic       rst_n,
    input logic       trig_n,
    input logic       lock,
    input logic       restart,
    input logic [7:0] deg,
    input logic [7:0] ang
);
    int low_run;
    int falls;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_run <= 0;
            falls   <= 0;
        end else begin
            low_run <= trig_n ? 0 : low_run + 1;
            if (restart)
                falls <= 0;
            else if (!trig_n && low_run == 0)
                falls <= falls + 1;
        end
    end

    p_width_max_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !trig_n |-> (low_run < PULSE_CYC));

    p_single_fire_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(trig_n) |-> (falls == 0));

    p_deg_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        deg <= 8'd180);

    p_off_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ang == 8'd0) |-> trig_n);

    p_unlocked_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !lock |=> trig_n);

    p_ang_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ang == 8'd0) || (ang >= 8'd41 && ang <= 8'd159));

    p_ang_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !restart |=> $stable(ang));
endmodule

bind phase_trigger_gen phtrig_checker #(.PULSE_CYC(PULSE_CYC)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .trig_n  (trig_n),
    .lock    (lock_w),
    .restart (edge_w),
    .deg     (deg_w),
    .ang     (ang_w)
);

// File: tb/phase_trigger_gen_tb_top.sv
module phase_trigger_gen_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int TB_CLK_HZ  = 100_000;
    localparam int PULSE      = 3;      // 100 kHz * 33 us, truncated
    localparam int LAT        = 3;      // sync stages + fire register
    localparam int TOL        = 3;
    localparam int NVEC       = 9;
    // half-cycle lengths in clocks: 60, 60, 60, 50, 40, 70, 60, 60, 50 Hz
    localparam int VEC_LEN [NVEC] = '{833, 833, 833, 1000, 1250, 714, 833, 833, 1000};
    localparam int VEC_ANG [NVEC] = '{100, 41, 159, 90, 60, 120, 20, 200, 0};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_sync = 1'b0;
    logic [7:0] cond_deg = 8'd0;
    wire        trig_n;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    phase_trigger_gen #(.CLK_HZ(TB_CLK_HZ)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_sync (line_sync),
        .cond_deg  (cond_deg),
        .trig_n    (trig_n)
    );

    function automatic int lim(input int c);
        if (c == 0) return 0;
        if (c < 41) return 41;
        if (c > 159) return 159;
        return c;
    endfunction

    function automatic int exp_fall(input int len, input int code);
        return LAT + ((180 - lim(code)) * len + 179) / 180;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // toggle sync, then observe one half-cycle of len clocks at falling edges
    task automatic run_half(input int len, input int chg_at, input int chg_val,
                            output int first_fall, output int nfalls, output int low_len);
        logic prev;
        prev       = trig_n;
        first_fall = -1;
        nfalls     = 0;
        low_len    = 0;
        line_sync  = ~line_sync;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (!trig_n) low_len++;
            if (prev && !trig_n) begin
                nfalls++;
                if (first_fall < 0) first_fall = i;
            end
            prev = trig_n;
            if (i == chg_at) cond_deg = 8'(chg_val);
        end
    endtask

    task automatic near(input int act, input int exp, input string req);
        check(act >= exp - TOL && act <= exp + TOL, req, "fall offset", act, exp);
    endtask

    initial begin
        #(CLK_PERIOD * 190_000);
        n_chk++;
        n_fail++;
        $display("FAIL all watchdog: actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int ff, nf, ll;
        string rq;
        repeat (5) @(negedge clk);
        check(trig_n == 1'b1, "R8", "trig_n in reset", trig_n, 1);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        check(trig_n == 1'b1, "R8", "trig_n after reset", trig_n, 1);

        // R8: first half-cycle after reset is unmeasured, second one fires
        cond_deg = 8'd100;
        run_half(833, -1, 0, ff, nf, ll);
        check(nf == 0, "R8", "pulses in first half", nf, 0);
        run_half(833, -1, 0, ff, nf, ll);
        check(nf == 1, "R8", "pulses in second half", nf, 1);

        // vector table: settle two halves, then measure the third
        for (int v = 0; v < NVEC; v++) begin
            cond_deg = 8'(VEC_ANG[v]);
            run_half(VEC_LEN[v], -1, 0, ff, nf, ll);
            run_half(VEC_LEN[v], -1, 0, ff, nf, ll);
            run_half(VEC_LEN[v], -1, 0, ff, nf, ll);
            if (VEC_ANG[v] == 0) begin
                check(nf == 0 && ll == 0, "R5", "pulses with code 0", nf, 0);
            end else begin
                rq = (lim(VEC_ANG[v]) != VEC_ANG[v]) ? "R4" : "R3";
                check(nf == 1, "R1", "pulses per half", nf, 1);
                check(ll == PULSE, "R2", "pulse width", ll, PULSE);
                near(ff, exp_fall(VEC_LEN[v], VEC_ANG[v]), rq);
            end
        end

        // R6: change the code inside a half-cycle
        cond_deg = 8'd60;
        run_half(833, -1, 0, ff, nf, ll);
        run_half(833, -1, 0, ff, nf, ll);
        run_half(833, 100, 150, ff, nf, ll);
        near(ff, exp_fall(833, 60), "R6");
        check(nf == 1, "R6", "pulses after early change", nf, 1);
        run_half(833, 300, 41, ff, nf, ll);
        near(ff, exp_fall(833, 150), "R6");
        check(nf == 1, "R6", "pulses after late change", nf, 1);
        run_half(833, -1, 0, ff, nf, ll);
        near(ff, exp_fall(833, 41), "R6");

        // R9: a too-short interval unlocks for the following half-cycle
        cond_deg = 8'd159;
        run_half(833, -1, 0, ff, nf, ll);
        run_half(833, -1, 0, ff, nf, ll);
        run_half(20, -1, 0, ff, nf, ll);
        run_half(833, -1, 0, ff, nf, ll);
        check(nf == 0, "R9", "pulses after short interval", nf, 0);
        run_half(833, -1, 0, ff, nf, ll);
        check(nf == 1, "R9", "pulses after relock", nf, 1);

        // R7: sync outage longer than the timeout
        repeat (4000) @(negedge clk);
        check(trig_n == 1'b1, "R7", "trig_n during outage", trig_n, 1);
        run_half(833, -1, 0, ff, nf, ll);
        check(nf == 0, "R7", "pulses in first half after outage", nf, 0);
        run_half(833, -1, 0, ff, nf, ll);
        check(nf == 1, "R7", "pulses in second half after outage", nf, 1);
        run_half(833, -1, 0, ff, nf, ll);
        near(ff, exp_fall(833, 159), "R7");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule